// File: doc/BRIEF.md
# Conditional Subroutine Return Sequencer

This block is the control and address slice of an 8-bit CPU with a 16-bit address space. It holds the program counter and the stack pointer and drives a byte-wide memory bus. One clock cycle is one T-state. The block executes three control-transfer instructions.

A subroutine call is three bytes long. It pushes the address of the instruction that follows it onto a stack that grows downward, and then jumps to its 16-bit operand. The conditional return is one byte long. It looks at one bit of the flag register, which arrives on an input. When that bit is 0 it pops the return address into the program counter. When that bit is 1 it falls through to the next instruction. The plain return pops with no test. By default the tested bit is the parity flag (bit 2), where 0 means odd parity.

Any other opcode is treated as a one-byte placeholder that only advances the program counter, because general instruction decode belongs to other blocks. After each instruction a one-cycle completion pulse presents the new program counter and stack pointer.

Top module: `rsq_sequencer`

## Requirements
- R1: While reset is held, `pc_o` equals PC_RESET (default 0x1240), `sp_o` equals SP_RESET (default 0x0001), and `done_o` and `wr_o` are low. Reset asserted in the middle of an instruction abandons that instruction.
- R2: Opcode 0xCD (call) takes 18 T-states: a 6-T opcode fetch, two 3-T operand reads and two 3-T stack writes. `rd_o` is high for 9 T-states and `wr_o` for 2. The program counter is then loaded with the operand: low byte at PC+1, high byte at PC+2.
- R3: A call writes the high byte of the return address (call address + 3) to SP-1 first, then the low byte to SP-2. It leaves SP decreased by 2.
- R4: Opcode 0xE0 (conditional return) with flag bit COND_BIT at 0 takes 12 T-states and has 9 read T-states. It reads the low byte from SP and the high byte from SP+1, loads them into the program counter, and leaves SP increased by 2.
- R5: Opcode 0xE0 with flag bit COND_BIT at 1 takes 6 T-states and has 3 read T-states and no write. It leaves PC+1 and an unchanged SP.
- R6: Flag bits other than COND_BIT have no effect on the conditional return's decision.
- R7: Opcode 0xC9 (plain return) takes 10 T-states with 9 read T-states. It performs the same pop as R4 whatever the flags are.
- R8: Any other opcode takes 4 T-states with 3 read T-states and advances PC by 1.
- R9: PC and SP arithmetic wraps modulo 2^16 (for example, a call from SP 0x0001 writes 0x0000 and 0xFFFF and leaves SP at 0xFFFF).
- R10: `done_o` is high for exactly one cycle after the last T-state of each instruction, with `pc_o`/`sp_o` already updated. `rd_o` and `wr_o` are never high together. `wr_o` is high only in T2 of a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| flags_i | input | 8 | Flag register; bit COND_BIT is tested by 0xE0 |
| rdata_i | input | 8 | Memory read data, valid during a read strobe |
| addr_o | output | 16 | Memory address |
| rd_o | output | 1 | Read strobe, T1 to T3 of fetch and read cycles |
| wr_o | output | 1 | Write strobe, T2 of stack write cycles |
| wdata_o | output | 8 | Write data |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| done_o | output | 1 | Instruction completion pulse |

## Verification
Read data is captured at the edge that ends T3 of each read cycle. The program counter and stack pointer take their new values at the edge that ends the final T-state, and the completion pulse appears in the same cycle as those values. The bench therefore samples at falling edges and counts cycles from the first T-state of an instruction until `done_o` is seen; that count must equal the T-state total. Strobes are tallied over exactly those cycles, and PC and SP are compared in the cycle that carries the pulse. Stack bytes are checked in the bench memory after each call, together with the address and data of the first write strobe, which fixes the push order.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam logic [7:0] OPC_CALL = 8'hCD;
    localparam logic [7:0] OPC_RET  = 8'hC9;
    localparam logic [7:0] OPC_CRET = 8'hE0;

    typedef enum logic [2:0] {
        MC_FETCH,
        MC_OPLO,
        MC_OPHI,
        MC_PUSHHI,
        MC_PUSHLO,
        MC_POPLO,
        MC_POPHI
    } mcyc_e;

    typedef enum logic [1:0] {
        K_OTHER,
        K_CALL,
        K_RET,
        K_CRET
    } kind_e;

endpackage

// File: rtl/rsq_decode.sv
module rsq_decode
    import rsq_pkg::*;
#(
    parameter int DW          = 8,
    parameter int TW          = 3,
    parameter int FETCH_LONG  = 6,
    parameter int FETCH_SHORT = 4
) (
    input  logic [DW-1:0] op_i,
    output kind_e         kind_o,
    output logic [TW-1:0] fetch_len_o
);
    always_comb begin
        kind_o      = K_OTHER;
        fetch_len_o = TW'(FETCH_SHORT);
        if (op_i == DW'(OPC_CALL)) begin
            kind_o      = K_CALL;
            fetch_len_o = TW'(FETCH_LONG);
        end else if (op_i == DW'(OPC_CRET)) begin
            kind_o      = K_CRET;
            fetch_len_o = TW'(FETCH_LONG);
        end else if (op_i == DW'(OPC_RET)) begin
            kind_o      = K_RET;
        end
    end
endmodule

// File: rtl/rsq_cond.sv
module rsq_cond
    import rsq_pkg::*;
#(
    parameter int DW       = 8,
    parameter int COND_BIT = 2
) (
    input  kind_e         kind_i,
    input  logic [DW-1:0] flags_i,
    output logic          take_pop_o
);
    localparam logic [DW-1:0] COND_MASK = DW'(1) << COND_BIT;

    logic flag_set;

    always_comb begin
        flag_set   = |(flags_i & COND_MASK);
        take_pop_o = (kind_i == K_RET) || ((kind_i == K_CRET) && !flag_set);
    end
endmodule

// File: rtl/rsq_core.sv
module rsq_core
    import rsq_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter int          TW       = 3,
    parameter logic [15:0] PC_RESET = 16'h1240,
    parameter logic [15:0] SP_RESET = 16'h0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rdata_i,
    input  kind_e         kind_i,
    input  logic [TW-1:0] fetch_len_i,
    input  logic          take_pop_i,
    output logic [DW-1:0] op_o,
    output logic [AW-1:0] addr_o,
    output logic          rd_o,
    output logic          wr_o,
    output logic [DW-1:0] wdata_o,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] sp_o,
    output logic          done_o
);
    localparam logic [TW-1:0] T_ONE  = TW'(1);
    localparam logic [TW-1:0] T_TWO  = TW'(2);
    localparam logic [TW-1:0] T_LAST = TW'(3);
    localparam logic [TW-1:0] T_OPC  = TW'(4);

    typedef struct packed {
        mcyc_e         mc;
        logic [TW-1:0] t;
        logic [DW-1:0] op;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic          done;
    } st_t;

    st_t q, d;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.t      = q.t + T_ONE;
        addr_o   = q.pc;
        rd_o     = 1'b0;
        wr_o     = 1'b0;
        wdata_o  = '0;
        case (q.mc)
            MC_FETCH: begin
                rd_o = (q.t <= T_LAST);
                if (q.t == T_LAST) begin
                    d.op = rdata_i;
                    d.pc = q.pc + AW'(1);
                end
                if ((q.t >= T_OPC) && (q.t == fetch_len_i)) begin
                    d.t = T_ONE;
                    case (kind_i)
                        K_CALL:  d.mc = MC_OPLO;
                        K_RET:   d.mc = MC_POPLO;
                        K_CRET: begin
                            if (take_pop_i) d.mc = MC_POPLO;
                            else            d.done = 1'b1;
                        end
                        default: d.done = 1'b1;
                    endcase
                end
            end
            MC_OPLO, MC_OPHI: begin
                rd_o = 1'b1;
                if (q.t == T_LAST) begin
                    d.t  = T_ONE;
                    d.pc = q.pc + AW'(1);
                    if (q.mc == MC_OPLO) begin
                        d.lo = rdata_i;
                        d.mc = MC_OPHI;
                    end else begin
                        d.hi = rdata_i;
                        d.mc = MC_PUSHHI;
                    end
                end
            end
            MC_PUSHHI, MC_PUSHLO: begin
                addr_o  = q.sp - AW'(1);
                wr_o    = (q.t == T_TWO);
                wdata_o = (q.mc == MC_PUSHHI) ? q.pc[AW-1:DW] : q.pc[DW-1:0];
                if (q.t == T_LAST) begin
                    d.t  = T_ONE;
                    d.sp = q.sp - AW'(1);
                    if (q.mc == MC_PUSHHI) begin
                        d.mc = MC_PUSHLO;
                    end else begin
                        d.mc   = MC_FETCH;
                        d.pc   = {q.hi, q.lo};
                        d.done = 1'b1;
                    end
                end
            end
            MC_POPLO, MC_POPHI: begin
                addr_o = q.sp;
                rd_o   = 1'b1;
                if (q.t == T_LAST) begin
                    d.t  = T_ONE;
                    d.sp = q.sp + AW'(1);
                    if (q.mc == MC_POPLO) begin
                        d.lo = rdata_i;
                        d.mc = MC_POPHI;
                    end else begin
                        d.pc   = {rdata_i, q.lo};
                        d.mc   = MC_FETCH;
                        d.done = 1'b1;
                    end
                end
            end
            default: begin
                d.mc = MC_FETCH;
                d.t  = T_ONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mc   <= MC_FETCH;
            q.t    <= T_ONE;
            q.op   <= '0;
            q.lo   <= '0;
            q.hi   <= '0;
            q.pc   <= AW'(PC_RESET);
            q.sp   <= AW'(SP_RESET);
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign op_o   = q.op;
    assign pc_o   = q.pc;
    assign sp_o   = q.sp;
    assign done_o = q.done;

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> !rd_o);

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);

    // R3
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mc == MC_PUSHHI && q.t == T_LAST) |=> (sp_o == AW'($past(sp_o) - AW'(1))));

    // R4
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mc == MC_POPLO && q.t == T_LAST) |=> (sp_o == AW'($past(sp_o) + AW'(1))));

    // R5
    fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mc == MC_FETCH && q.t >= T_OPC && q.t == fetch_len_i &&
         kind_i == K_CRET && !take_pop_i) |=> ($stable(sp_o) && done_o));

endmodule

// File: rtl/rsq_sequencer.sv
module rsq_sequencer
    import rsq_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter int          COND_BIT = 2,
    parameter logic [15:0] PC_RESET = 16'h1240,
    parameter logic [15:0] SP_RESET = 16'h0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] flags_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW-1:0] addr_o,
    output logic          rd_o,
    output logic          wr_o,
    output logic [DW-1:0] wdata_o,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] sp_o,
    output logic          done_o
);
    localparam int TW = 3;

    logic [DW-1:0] op_q;
    kind_e         kind;
    logic [TW-1:0] fetch_len;
    logic          take_pop;

    rsq_decode #(.DW(DW), .TW(TW)) decode_i (
        .op_i        (op_q),
        .kind_o      (kind),
        .fetch_len_o (fetch_len)
    );

    rsq_cond #(.DW(DW), .COND_BIT(COND_BIT)) cond_i (
        .kind_i     (kind),
        .flags_i    (flags_i),
        .take_pop_o (take_pop)
    );

    rsq_core #(
        .AW(AW), .DW(DW), .TW(TW),
        .PC_RESET(PC_RESET), .SP_RESET(SP_RESET)
    ) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rdata_i     (rdata_i),
        .kind_i      (kind),
        .fetch_len_i (fetch_len),
        .take_pop_i  (take_pop),
        .op_o        (op_q),
        .addr_o      (addr_o),
        .rd_o        (rd_o),
        .wr_o        (wr_o),
        .wdata_o     (wdata_o),
        .pc_o        (pc_o),
        .sp_o        (sp_o),
        .done_o      (done_o)
    );
endmodule

// File: tb/rsq_sequencer_tb_top.sv
module rsq_sequencer_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] PC0 = 16'h1240;
    localparam logic [15:0] SP0 = 16'h0001;

    typedef struct packed {
        logic [7:0]  flags;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [4:0]  t;
        logic [3:0]  rd;
        logic [1:0]  wr;
    } vec_t;

    // flags, expected pc, sp, T-states, read T-states, write strobes
    localparam vec_t VEC [10] = '{
        '{8'h00, 16'h1250, 16'hFFFF, 5'd18, 4'd9, 2'd2},  // call 0x1250
        '{8'h04, 16'h1251, 16'hFFFF, 5'd6,  4'd3, 2'd0},  // cond ret, not taken
        '{8'h00, 16'h1252, 16'hFFFF, 5'd4,  4'd3, 2'd0},  // other opcode
        '{8'h00, 16'h1260, 16'hFFFD, 5'd18, 4'd9, 2'd2},  // call 0x1260
        '{8'h00, 16'h1255, 16'hFFFF, 5'd12, 4'd9, 2'd0},  // cond ret, taken
        '{8'h04, 16'h1243, 16'h0001, 5'd10, 4'd9, 2'd0},  // plain ret
        '{8'hFF, 16'h1244, 16'h0001, 5'd6,  4'd3, 2'd0},  // other bits set, tested set
        '{8'hFB, 16'h1280, 16'h0003, 5'd12, 4'd9, 2'd0},  // other bits set, tested clear
        '{8'h00, 16'h1290, 16'h0005, 5'd10, 4'd9, 2'd0},  // plain ret
        '{8'h00, 16'h1291, 16'h0005, 5'd4,  4'd3, 2'd0}   // other opcode
    };
    localparam string VREQ [10] = '{"R2", "R5", "R8", "R2", "R4", "R7", "R6", "R6", "R7", "R8"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  flags = 8'h00;
    logic [7:0]  rdata;
    logic [15:0] addr;
    logic        rd, wr, done;
    logic [7:0]  wdata;
    logic [15:0] pc, sp;
    logic [7:0]  mem [256];
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsq_sequencer #(.PC_RESET(PC0), .SP_RESET(SP0)) dut_i (
        .clk(clk), .rst_n(rst_n), .flags_i(flags), .rdata_i(rdata),
        .addr_o(addr), .rd_o(rd), .wr_o(wr), .wdata_o(wdata),
        .pc_o(pc), .sp_o(sp), .done_o(done)
    );

    assign rdata = mem[addr[7:0]];

    always @(posedge clk) if (wr) mem[addr[7:0]] <= wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_instr(input logic [7:0] fl, output int nt, output int nrd,
                             output int nwr, output logic [15:0] wa, output logic [7:0] wd);
        flags = fl;
        nt = 0; nrd = 0; nwr = 0; wa = 16'h0; wd = 8'h0;
        while (1) begin
            if (rd) nrd++;
            if (wr) begin
                if (nwr == 0) begin wa = addr; wd = wdata; end
                nwr++;
            end
            nt++;
            @(negedge clk);
            if (done || nt > 40) break;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int nt, nrd, nwr;
        logic [15:0] wa;
        logic [7:0]  wd;
        for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        #1;
        mem[8'h40] <= 8'hCD; mem[8'h41] <= 8'h50; mem[8'h42] <= 8'h12;
        mem[8'h43] <= 8'hE0; mem[8'h44] <= 8'hE0;
        mem[8'h50] <= 8'hE0; mem[8'h51] <= 8'h00;
        mem[8'h52] <= 8'hCD; mem[8'h53] <= 8'h60; mem[8'h54] <= 8'h12;
        mem[8'h55] <= 8'hC9; mem[8'h60] <= 8'hE0; mem[8'h80] <= 8'hC9; mem[8'h90] <= 8'h76;
        mem[8'h01] <= 8'h80; mem[8'h02] <= 8'h12; mem[8'h03] <= 8'h90; mem[8'h04] <= 8'h12;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc, PC0);
        chk("R1 sp", sp, SP0);
        chk("R1 done", done, 0);
        chk("R1 wr", wr, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 10; v++) begin
            run_instr(VEC[v].flags, nt, nrd, nwr, wa, wd);
            chk({VREQ[v], " done"}, done, 1);
            chk({VREQ[v], " pc"}, pc, VEC[v].pc);
            chk({VREQ[v], " sp"}, sp, VEC[v].sp);
            chk({VREQ[v], " tstates"}, nt, VEC[v].t);
            chk({VREQ[v], " R10 read strobes"}, nrd, VEC[v].rd);
            chk({VREQ[v], " R10 write strobes"}, nwr, VEC[v].wr);
            if (v == 0) begin
                // R3 push order and bytes; R9 wrap below zero
                chk("R3 first write addr", wa, 16'h0000);
                chk("R3 first write data", wd, 8'h12);
                chk("R3 hi byte at SP-1", mem[8'h00], 8'h12);
                chk("R3 lo byte at SP-2", mem[8'hFF], 8'h43);
                chk("R9 sp wrap down", sp, 16'hFFFF);
            end
            if (v == 3) begin
                chk("R3 hi byte nested", mem[8'hFE], 8'h12);
                chk("R3 lo byte nested", mem[8'hFD], 8'h55);
                chk("R3 first write addr nested", wa, 16'hFFFE);
            end
            if (v == 5) chk("R9 sp wrap up", sp, 16'h0001);
        end
        @(negedge clk);
        chk("R10 done one cycle", done, 0);

        // R1 reset in mid-instruction
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid pc", pc, PC0);
        chk("R1 mid sp", sp, SP0);
        chk("R1 mid wr", wr, 0);
        chk("R1 mid done", done, 0);
        rst_n = 1'b1;
        run_instr(8'h00, nt, nrd, nwr, wa, wd);
        chk("R2 call after reset pc", pc, 16'h1250);
        chk("R2 call after reset tstates", nt, 18);
        chk("R9 call after reset sp", sp, 16'hFFFF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule